// File: doc/BRIEF.md
# SPI Slave Register Access Port

This block lets an SPI host in clock mode 0 read and write a small byte-addressed register space inside a larger design. The host lowers chip select, sends a command byte and then clocks one or more data bytes. Bit 7 of the command selects the direction and bits 6:0 select the starting address. The address steps by one after every byte, so a single select period can cover a run of neighbouring registers. SCK, MOSI and chip select are sampled by the system clock through synchronizers, and edges are detected in that clock domain. The system clock must run at least four times faster than SCK.

The register space has four kinds of entry:
- A bank of configuration bytes that can be read and written.
- A write-only action register. Five of its bits give single-cycle strobes and two of its bits drive held actuator levels.
- A wide measurement word. One read frame returns 24 data bits followed by an error flag and a warning flag.
- Three status bytes. Reading one of them sends a one-cycle clear request back to the logic that latches that status.

Top module: `spi_regport`

## Requirements
- R1: After a synchronous reset, the following outputs are all zero: MISO enable, configuration outputs, action strobes, actuator levels and status clear strobes.
- R2: MISO is driven (spi_miso_oe = 1) only while chip select is low, after synchronization. While chip select is high, spi_miso_oe = 0.
- R3: Chip select is sampled low, and a command byte with bit 7 = 0 and address A in 0x00..0x07 is received. Each following data byte, received MSB first, is then written into configuration byte A, which appears on cfg_o[8A+7:8A]. The configuration never changes while chip select is high.
- R4: A command byte with bit 7 = 1 starts a read. The addressed byte is shifted out MSB first. Its first bit appears on the SCK falling edge right after the rising edge that sampled the last command bit. Each later bit follows on the next falling edge.
- R5: After every data byte the address increments by one, for both reads and writes. The address wraps from 0x7F to 0x00.
- R6: Writing byte D to address 0x30 drives act_pulse = D[4:0] for exactly one system clock. It also sets act_level = D[6:5], which holds until the next write to 0x30. Reading 0x30 returns 0x00.
- R7: A read at address 0x0A returns four bytes in one frame: meas_i[23:0] MSB first, then meas_err, then meas_warn, then six zero bits. All four bytes are taken from one snapshot captured when the first byte is loaded. A byte read after those four comes from address 0x0B.
- R8: Reading address 0x48+k (k = 0..2) returns status_i[8k+7:8k]. Each completed byte read from that address pulses status_clr[k] for one clock. At most one clear bit is high at a time.
- R9: A rising edge on chip select ends the transfer. An unfinished byte is discarded, and the next transfer starts again with a command byte.
- R10: Writes to addresses other than 0x00..0x07 and 0x30 change nothing. Reads from addresses other than the configuration bytes, 0x0A, 0x30 and 0x48..0x4A return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the SCK rate |
| rst | input | 1 | Synchronous active-high reset |
| spi_ncs | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Drive enable for spi_miso; high-impedance when 0 |
| cfg_o | output | 64 | Configuration bytes, byte i at bits 8i+7:8i |
| act_pulse | output | 5 | One-cycle action strobes from the action register |
| act_level | output | 2 | Held actuator levels from the action register |
| meas_i | input | 24 | Measurement value |
| meas_err | input | 1 | Error flag appended to measurement reads |
| meas_warn | input | 1 | Warning flag appended to measurement reads |
| status_i | input | 24 | Three latched status bytes |
| status_clr | output | 3 | One-cycle clear request per status byte |

## Verification
The bench targets the following corner cases:
- Read timing. A design that loads read data one SCK edge late returns every byte shifted by one bit.
- Status clearing. A design that clears status speculatively, on the byte it pre-loads after the last byte read, clears a status address that the host never read.
- Measurement frame. A design that advances the address inside the four-byte frame returns a misplaced flag pair or the wrong following byte.
- Address wrap. A wrong wrap from 0x7F corrupts configuration byte 0.
- Aborted byte. A design that keeps a half-received byte writes garbage.
- Action register. A design that holds the action strobes for more than a cycle shows a pulse count other than one, and a design that clears the actuator bits loses act_level.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_regport_framer.sv
module spi_regport_framer
  import spi_regport_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  ncs_s,
  input  logic  sck_rise,
  input  logic  sck_fall,
  input  logic  mosi_s,
  input  logic  tx_load,
  input  byte_t tx_byte,
  output logic  byte_done,
  output byte_t rx_byte,
  output logic  miso
);
  localparam int CW = $clog2(BYTE_W);

  logic [CW-1:0] bit_cnt;
  byte_t         rx_sr;
  byte_t         tx_sr;
  logic          miso_q;

  assign byte_done = sck_rise && (bit_cnt == CW'(BYTE_W - 1));
  assign rx_byte   = {rx_sr[BYTE_W-2:0], mosi_s};
  assign miso      = miso_q;

  always_ff @(posedge clk) begin
    if (rst || ncs_s) begin
      bit_cnt <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      miso_q  <= 1'b0;
    end else begin
      if (sck_rise) begin
        rx_sr   <= rx_byte;
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (sck_fall) begin
        miso_q <= tx_sr[BYTE_W-1];
        tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b0};
      end
      if (tx_load) tx_sr <= tx_byte;
    end
  end

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst) ncs_s |=> (bit_cnt == '0)); // R9
  AST_LOAD_APART: assert property (@(posedge clk) disable iff (rst) tx_load |-> !sck_fall); // R4
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int NCFG = 8,
  parameter int NSTAT = 3,
  parameter int MEAS_W = 24,
  parameter int NPULSE = 5,
  parameter int NLEVEL = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [6:0] INSTR_ADDR = 7'h30,
  parameter logic [6:0] MEAS_ADDR = 7'h0A,
  parameter logic [6:0] STAT_BASE = 7'h48
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  spi_ncs,
  input  logic                  spi_sck,
  input  logic                  spi_mosi,
  output logic                  spi_miso,
  output logic                  spi_miso_oe,
  output logic [NCFG*8-1:0]     cfg_o,
  output logic [NPULSE-1:0]     act_pulse,
  output logic [NLEVEL-1:0]     act_level,
  input  logic [MEAS_W-1:0]     meas_i,
  input  logic                  meas_err,
  input  logic                  meas_warn,
  input  logic [NSTAT*8-1:0]    status_i,
  output logic [NSTAT-1:0]      status_clr
);
  localparam int CFG_AW     = (NCFG > 1) ? $clog2(NCFG) : 1;
  localparam int MEAS_BYTES = (MEAS_W + 2 + BYTE_W - 1) / BYTE_W;
  localparam int MW         = MEAS_BYTES * BYTE_W;
  localparam int MEAS_PAD   = MW - MEAS_W - 2;
  localparam int MIW        = (MEAS_BYTES > 1) ? $clog2(MEAS_BYTES) : 1;
  localparam addr_t CFG_END  = addr_t'(NCFG);
  localparam addr_t STAT_END = STAT_BASE + addr_t'(NSTAT);

  logic ncs_s, sck_s, mosi_s, sck_q;
  logic sck_rise, sck_fall;
  logic byte_done, load_pend;
  byte_t rx_byte, tx_byte;

  logic     have_cmd, rd_mode, meas_busy;
  addr_t    addr;
  logic [MIW-1:0] meas_idx;
  logic [MW-1:0]  meas_snap, meas_word;
  byte_t    cfg_q [NCFG];
  logic     wr_fire, instr_we, in_stat;

  spi_regport_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst),
    .d_i({spi_ncs, spi_sck, spi_mosi}),
    .q_o({ncs_s, sck_s, mosi_s})
  );

  always_ff @(posedge clk) begin
    if (rst) sck_q <= 1'b0;
    else     sck_q <= sck_s;
  end

  assign sck_rise = !ncs_s && sck_s && !sck_q;
  assign sck_fall = !ncs_s && !sck_s && sck_q;

  spi_regport_framer u_framer (
    .clk(clk), .rst(rst), .ncs_s(ncs_s),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s),
    .tx_load(load_pend), .tx_byte(tx_byte),
    .byte_done(byte_done), .rx_byte(rx_byte), .miso(spi_miso)
  );

  assign meas_word = MW'({meas_i, meas_err, meas_warn}) << MEAS_PAD;
  assign wr_fire   = byte_done && have_cmd && !rd_mode;
  assign instr_we  = wr_fire && (addr == INSTR_ADDR);
  assign in_stat   = (addr >= STAT_BASE) && (addr < STAT_END);

  // read byte selection for the next load
  always_comb begin
    tx_byte = '0;
    if (meas_busy)
      tx_byte = meas_snap[(MEAS_BYTES - 1 - int'(meas_idx)) * BYTE_W +: BYTE_W];
    else if (addr == MEAS_ADDR)
      tx_byte = meas_word[MW-1 -: BYTE_W];
    else if (addr < CFG_END)
      tx_byte = cfg_q[addr[CFG_AW-1:0]];
    else if (in_stat)
      tx_byte = status_i[int'(addr - STAT_BASE) * BYTE_W +: BYTE_W];
  end

  // transfer sequencing, cleared by chip select high
  always_ff @(posedge clk) begin
    if (rst || ncs_s) begin
      have_cmd  <= 1'b0;
      rd_mode   <= 1'b0;
      addr      <= '0;
      load_pend <= 1'b0;
      meas_busy <= 1'b0;
      meas_idx  <= '0;
    end else begin
      load_pend <= 1'b0;
      if (byte_done) begin
        if (!have_cmd) begin
          have_cmd  <= 1'b1;
          rd_mode   <= rx_byte[7];
          addr      <= rx_byte[6:0];
          load_pend <= rx_byte[7];
        end else begin
          load_pend <= rd_mode;
          if (!(rd_mode && meas_busy)) addr <= addr + 1'b1;
        end
      end
      if (load_pend) begin
        if (meas_busy) begin
          meas_idx <= meas_idx + 1'b1;
          if (meas_idx == MIW'(MEAS_BYTES - 1)) meas_busy <= 1'b0;
        end else if (addr == MEAS_ADDR) begin
          meas_busy <= 1'b1;
          meas_idx  <= MIW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) meas_snap <= '0;
    else if (load_pend && !meas_busy && addr == MEAS_ADDR) meas_snap <= meas_word;
  end

  // register file and registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCFG; i++) cfg_q[i] <= '0;
      act_pulse   <= '0;
      act_level   <= '0;
      status_clr  <= '0;
      spi_miso_oe <= 1'b0;
    end else begin
      spi_miso_oe <= !ncs_s;
      act_pulse   <= instr_we ? rx_byte[NPULSE-1:0] : '0;
      if (instr_we) act_level <= rx_byte[NPULSE +: NLEVEL];
      if (wr_fire && addr < CFG_END) cfg_q[addr[CFG_AW-1:0]] <= rx_byte;
      status_clr <= '0;
      if (byte_done && have_cmd && rd_mode && in_stat)
        status_clr <= NSTAT'(1) << (addr - STAT_BASE);
    end
  end

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg_out
    assign cfg_o[g*BYTE_W +: BYTE_W] = cfg_q[g];
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst) (act_pulse != '0) |=> (act_pulse == '0)); // R6
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst) !instr_we |=> $stable(act_level)); // R6
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(status_clr)); // R8
  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (rst) (status_clr != '0) |=> (status_clr == '0)); // R8
  AST_CFG_IDLE: assert property (@(posedge clk) disable iff (rst) ncs_s |=> $stable(cfg_o)); // R3
endmodule

// File: tb/spi_regport_test.sv
module spi_regport_test;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_ncs = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe;
  logic [63:0] cfg_o;
  logic [4:0]  act_pulse;
  logic [1:0]  act_level;
  logic [23:0] meas_i = '0;
  logic        meas_err = 1'b0, meas_warn = 1'b0;
  logic [23:0] status_i = '0;
  logic [2:0]  status_clr;

  always #2 clk = ~clk;

  spi_regport uut (
    .clk(clk), .rst(rst), .spi_ncs(spi_ncs), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe), .cfg_o(cfg_o),
    .act_pulse(act_pulse), .act_level(act_level), .meas_i(meas_i),
    .meas_err(meas_err), .meas_warn(meas_warn), .status_i(status_i),
    .status_clr(status_clr)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] cfg_m [8];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];
  int pulse_cycles = 0;
  logic [4:0] pulse_or = '0;
  int clr_cnt [3];

  always @(negedge clk) begin
    if (act_pulse != 5'd0) begin pulse_cycles++; pulse_or |= act_pulse; end
    for (int k = 0; k < 3; k++) if (status_clr[k]) clr_cnt[k]++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model_flat();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = cfg_m[i];
    return v;
  endfunction

  task automatic spi_bits(input logic [7:0] b, input int nb, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      spi_mosi = b[i];
      tick(HALF);
      r[i] = spi_miso;
      spi_sck = 1'b1;
      tick(HALF);
      spi_sck = 1'b0;
    end
  endtask

  task automatic frame_begin();
    spi_ncs = 1'b0;
    tick(4);
  endtask

  task automatic frame_end();
    tick(HALF);
    spi_ncs = 1'b1;
    spi_mosi = 1'b0;
    tick(8);
  endtask

  task automatic spi_xfer(input logic [7:0] cmd, input int n);
    logic [7:0] d;
    frame_begin();
    spi_bits(cmd, 8, d);
    chk("R2 oe during frame", {63'd0, spi_miso_oe}, 64'd1);
    for (int k = 0; k < n; k++) begin
      spi_bits(wbuf[k], 8, d);
      rbuf[k] = d;
    end
    frame_end();
  endtask

  task automatic clr_tallies();
    pulse_cycles = 0;
    pulse_or = '0;
    for (int k = 0; k < 3; k++) clr_cnt[k] = 0;
  endtask

  initial begin
    #(4 * 180000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [7:0] d;
    int a, len;
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 8; i++) cfg_m[i] = '0;
    for (int i = 0; i < 16; i++) wbuf[i] = '0;
    clr_tallies();
    tick(5);
    rst = 1'b0;
    tick(3);

    // R1 reset state
    chk("R1 miso_oe", {63'd0, spi_miso_oe}, 64'd0);
    chk("R1 cfg_o", cfg_o, 64'd0);
    chk("R1 act_level", {62'd0, act_level}, 64'd0);
    chk("R1 act_pulse", {59'd0, act_pulse}, 64'd0);
    chk("R1 status_clr", {61'd0, status_clr}, 64'd0);

    // R3 single write, R4 read back
    wbuf[0] = 8'hA5;
    spi_xfer({1'b0, 7'd3}, 1);
    cfg_m[3] = 8'hA5;
    chk("R3 single write", cfg_o, model_flat());
    wbuf[0] = 8'h00;
    spi_xfer({1'b1, 7'd3}, 1);
    chk("R4 single read", {56'd0, rbuf[0]}, {56'd0, 8'hA5});
    chk("R2 oe idle", {63'd0, spi_miso_oe}, 64'd0);

    // R5 burst write and burst read
    for (int i = 0; i < 8; i++) begin wbuf[i] = 8'($urandom); cfg_m[i] = wbuf[i]; end
    spi_xfer({1'b0, 7'd0}, 8);
    chk("R5 burst write", cfg_o, model_flat());
    for (int i = 0; i < 8; i++) wbuf[i] = '0;
    spi_xfer({1'b1, 7'd0}, 8);
    for (int i = 0; i < 8; i++) chk("R5 burst read", {56'd0, rbuf[i]}, {56'd0, cfg_m[i]});

    // R10 reading past the configuration bank
    spi_xfer({1'b1, 7'd6}, 4);
    chk("R5 read cfg6", {56'd0, rbuf[0]}, {56'd0, cfg_m[6]});
    chk("R5 read cfg7", {56'd0, rbuf[1]}, {56'd0, cfg_m[7]});
    chk("R10 unmapped 0x08", {56'd0, rbuf[2]}, 64'd0);
    chk("R10 unmapped 0x09", {56'd0, rbuf[3]}, 64'd0);

    // random write/read bursts
    for (int it = 0; it < 20; it++) begin
      a = $urandom_range(0, 7);
      len = $urandom_range(1, 8 - a);
      for (int i = 0; i < len; i++) begin wbuf[i] = 8'($urandom); cfg_m[a+i] = wbuf[i]; end
      spi_xfer({1'b0, 7'(a)}, len);
      chk("R3 random write", cfg_o, model_flat());
      for (int i = 0; i < 8; i++) wbuf[i] = '0;
      spi_xfer({1'b1, 7'd0}, 8);
      for (int i = 0; i < 8; i++) chk("R5 random read", {56'd0, rbuf[i]}, {56'd0, cfg_m[i]});
    end

    // R6 action register
    clr_tallies();
    wbuf[0] = 8'h7F;
    spi_xfer({1'b0, 7'h30}, 1);
    chk("R6 pulse cycles", 64'(pulse_cycles), 64'd1);
    chk("R6 pulse bits", {59'd0, pulse_or}, {59'd0, 5'h1F});
    chk("R6 levels set", {62'd0, act_level}, {62'd0, 2'b11});
    clr_tallies();
    wbuf[0] = 8'h20;
    spi_xfer({1'b0, 7'h30}, 1);
    chk("R6 no pulse", 64'(pulse_cycles), 64'd0);
    chk("R6 levels held", {62'd0, act_level}, {62'd0, 2'b01});
    wbuf[0] = 8'h00;
    spi_xfer({1'b1, 7'h30}, 1);
    chk("R6 write-only reads zero", {56'd0, rbuf[0]}, 64'd0);
    chk("R6 level after read", {62'd0, act_level}, {62'd0, 2'b01});
    chk("R10 cfg untouched by 0x30", cfg_o, model_flat());

    // R7 measurement frame
    for (int it = 0; it < 4; it++) begin
      meas_i = 24'($urandom);
      meas_err = 1'($urandom);
      meas_warn = 1'($urandom);
      w = {meas_i, meas_err, meas_warn, 6'b0};
      for (int i = 0; i < 6; i++) wbuf[i] = '0;
      spi_xfer({1'b1, 7'h09}, 6);
      chk("R10 unmapped 0x09", {56'd0, rbuf[0]}, 64'd0);
      chk("R7 meas byte0", {56'd0, rbuf[1]}, {56'd0, w[31:24]});
      chk("R7 meas byte1", {56'd0, rbuf[2]}, {56'd0, w[23:16]});
      chk("R7 meas byte2", {56'd0, rbuf[3]}, {56'd0, w[15:8]});
      chk("R7 meas flags", {56'd0, rbuf[4]}, {56'd0, w[7:0]});
      chk("R7 byte after frame", {56'd0, rbuf[5]}, 64'd0);
    end

    // R8 status reads and clear strobes
    status_i = 24'($urandom);
    clr_tallies();
    spi_xfer({1'b1, 7'h48}, 3);
    for (int k = 0; k < 3; k++) begin
      chk("R8 status byte", {56'd0, rbuf[k]}, {56'd0, status_i[k*8 +: 8]});
      chk("R8 clear count", 64'(clr_cnt[k]), 64'd1);
    end
    spi_xfer({1'b1, 7'h49}, 1);
    chk("R8 single read byte", {56'd0, rbuf[0]}, {56'd0, status_i[15:8]});
    chk("R8 clr0 after 0x49", 64'(clr_cnt[0]), 64'd1);
    chk("R8 clr1 after 0x49", 64'(clr_cnt[1]), 64'd2);
    chk("R8 clr2 after 0x49", 64'(clr_cnt[2]), 64'd1);

    // R10 writes to read-only and unmapped addresses
    clr_tallies();
    wbuf[0] = 8'hFF; wbuf[1] = 8'h5A; wbuf[2] = 8'hC3;
    spi_xfer({1'b0, 7'h4A}, 3);
    wbuf[0] = 8'h77;
    spi_xfer({1'b0, 7'h0A}, 1);
    chk("R10 cfg unchanged", cfg_o, model_flat());
    chk("R10 no clear on write", 64'(clr_cnt[0] + clr_cnt[1] + clr_cnt[2]), 64'd0);
    chk("R10 no pulse on write", 64'(pulse_cycles), 64'd0);

    // R5 address wrap 0x7F -> 0x00
    wbuf[0] = 8'h11; wbuf[1] = 8'h9E;
    spi_xfer({1'b0, 7'h7F}, 2);
    cfg_m[0] = 8'h9E;
    chk("R5 wrap write", cfg_o, model_flat());

    // R9 aborted byte and aborted command
    frame_begin();
    spi_bits({1'b0, 7'd2}, 8, d);
    spi_bits(8'h3C, 5, d);
    frame_end();
    chk("R9 partial byte discarded", cfg_o, model_flat());
    chk("R2 oe after abort", {63'd0, spi_miso_oe}, 64'd0);
    frame_begin();
    spi_bits({1'b0, 7'd1}, 4, d);
    frame_end();
    wbuf[0] = '0;
    spi_xfer({1'b1, 7'd2}, 1);
    chk("R9 new command after abort", {56'd0, rbuf[0]}, {56'd0, cfg_m[2]});
    chk("R9 cfg after aborts", cfg_o, model_flat());

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule